// File: doc/BRIEF.md
# Cache Line Retirement Controller

This block sits beside an ECC-protected external cache and listens to its correctable-error reports. Reports for one cache line that keep arriving point to a solid fault rather than a one-time upset, so the block counts them. Once the count for a line rises above a programmable threshold, the line is retired: its index goes into one of two retirement slots, and from then on the lookup port flags it. The cache's allocation and hit logic must then treat that line as unusable.

The controller has exactly two retirement slots. When a third line crosses the threshold, the cache keeps running, but a sticky deferred-repair request is raised. If the system is re-initialized while that request is still pending, the controller enters a sticky bypass state. In bypass the whole cache is deconfigured: every index looks up as unusable. Only a full reset clears the repair request and the bypass state. A re-initialization pulse does not clear them.

Top module: `line_retire_ctrl`

## Requirements
- R1: After reset, both slot valid bits are 0, the repair flag is 0, bypass is 0, and the lookup reports no index as retired.
- R2: A report counts only when `err_valid_i`=1 and `err_ce_i`=1. The report that brings a line's consecutive count above `thr_i` retires that line. The slot outputs and the lookup show the retirement right after the clock edge that samples that report. With `thr_i`=0, the first report retires the line.
- R3: A single tracking counter is used. A counted report for a different index restarts the count at 1 for the new index.
- R4: Uncorrectable reports (`err_ce_i`=0) and cycles with `err_valid_i`=0 change neither the count nor the slots.
- R5: Slots fill in order. Slot 0 (`slot_vld_o[0]`, `slot0_idx_o`) fills first, then slot 1 (`slot_vld_o[1]`, `slot1_idx_o`). `lookup_del_o` is 1, combinationally, when `lookup_idx_i` equals the index in a valid slot.
- R6: Reports for an index that is already retired are ignored. They consume no slot, do not raise repair, and do not disturb the count in progress.
- R7: A line that crosses the threshold while both slots are full sets `repair_o`. The slots stay unchanged. `repair_o` stays set until reset.
- R8: A one-cycle `boot_i` pulse clears the count in progress. If `repair_o` is set at that moment, `bypass_o` becomes 1 and stays 1 until reset. Otherwise `bypass_o` stays 0.
- R9: While `bypass_o`=1, `lookup_del_o` is 1 for every index, and error reports change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous full reset |
| boot_i | input | 1 | Re-initialization pulse |
| thr_i | input | CNT_W | Error threshold; retirement happens when the count exceeds it |
| err_valid_i | input | 1 | Error report strobe |
| err_idx_i | input | IDX_W | Line index of the report |
| err_ce_i | input | 1 | 1 = corrected error, 0 = uncorrectable |
| lookup_idx_i | input | IDX_W | Index to query |
| lookup_del_o | output | 1 | Queried index is retired, or the cache is bypassed |
| slot_vld_o | output | 2 | Valid bits of the two retirement slots |
| slot0_idx_o | output | IDX_W | Index held in slot 0 |
| slot1_idx_o | output | IDX_W | Index held in slot 1 |
| repair_o | output | 1 | Sticky deferred-repair request |
| bypass_o | output | 1 | Sticky whole-cache bypass |

## Verification
The bench drives runs of reports on one index to find the exact report that causes retirement. It interleaves a second index to show that the single counter restarts. It sends uncorrectable reports and idle cycles on an index to show they are not counted. Repeated reports on an already retired index show that no slot is consumed. A third failing line shows the repair escalation rather than a slot overwrite. Two re-initializations, one with the repair request pending and one without, distinguish bypass entry from a plain clearing of the counter.

// File: rtl/line_retire_ctrl.sv
module line_retire_ctrl #(
  parameter int IDX_W = 10,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boot_i,
  input  logic [CNT_W-1:0] thr_i,
  input  logic             err_valid_i,
  input  logic [IDX_W-1:0] err_idx_i,
  input  logic             err_ce_i,
  input  logic [IDX_W-1:0] lookup_idx_i,
  output logic             lookup_del_o,
  output logic [1:0]       slot_vld_o,
  output logic [IDX_W-1:0] slot0_idx_o,
  output logic [IDX_W-1:0] slot1_idx_o,
  output logic             repair_o,
  output logic             bypass_o
);

  logic [1:0]       vld;
  logic [IDX_W-1:0] s0, s1, trk_idx;
  logic             trk_vld, repair, bypass;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   nxt;
  logic             dup, same, take, fire;

  assign dup  = (vld[0] && err_idx_i == s0) || (vld[1] && err_idx_i == s1);
  assign take = err_valid_i && err_ce_i && !bypass && !dup;
  assign same = trk_vld && trk_idx == err_idx_i;
  assign nxt  = same ? {1'b0, cnt} + 1'b1 : (CNT_W+1)'(1);
  assign fire = take && (nxt > {1'b0, thr_i});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0; s0 <= '0; s1 <= '0;
      trk_idx <= '0; trk_vld <= 1'b0; cnt <= '0;
      repair <= 1'b0; bypass <= 1'b0;
    end else if (boot_i) begin
      trk_vld <= 1'b0;
      cnt     <= '0;
      bypass  <= bypass | repair;
    end else if (take) begin
      if (fire) begin
        trk_vld <= 1'b0;
        cnt     <= '0;
        if (!vld[0]) begin
          s0 <= err_idx_i; vld[0] <= 1'b1;
        end else if (!vld[1]) begin
          s1 <= err_idx_i; vld[1] <= 1'b1;
        end else begin
          repair <= 1'b1;
        end
      end else begin
        trk_idx <= err_idx_i;
        trk_vld <= 1'b1;
        cnt     <= nxt[CNT_W-1:0];
      end
    end
  end

  assign lookup_del_o = bypass || (vld[0] && lookup_idx_i == s0) ||
                        (vld[1] && lookup_idx_i == s1);
  assign slot_vld_o  = vld;
  assign slot0_idx_o = s0;
  assign slot1_idx_o = s1;
  assign repair_o    = repair;
  assign bypass_o    = bypass;

  AST_RETIRE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld[0]) |-> $past(err_valid_i && err_ce_i)); // R2
  AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    vld[1] |-> vld[0]); // R5
  AST_NO_DUP_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (vld == 2'b11) |-> (s0 != s1)); // R6
  AST_REPAIR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    repair |=> repair); // R7
  AST_BYPASS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_i && repair) |=> bypass); // R8
  AST_BYPASS_ONLY_ON_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && !(boot_i && repair)) |=> !bypass); // R8
  AST_BYPASS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> $stable(vld)); // R9

endmodule

// File: tb/line_retire_ctrl_tb.sv
module line_retire_ctrl_tb;
  localparam int IW = 10;
  localparam int CW = 4;

  logic clk = 0, rst_n = 0, boot = 0, ev = 0, ce = 0;
  logic [CW-1:0] thr = 2;
  logic [IW-1:0] eidx = '0, lidx = '0;
  logic lk; logic [1:0] sv; logic [IW-1:0] s0, s1; logic rep, byp;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  line_retire_ctrl #(.IDX_W(IW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .boot_i(boot), .thr_i(thr),
    .err_valid_i(ev), .err_idx_i(eidx), .err_ce_i(ce),
    .lookup_idx_i(lidx), .lookup_del_o(lk), .slot_vld_o(sv),
    .slot0_idx_o(s0), .slot1_idx_o(s1), .repair_o(rep), .bypass_o(byp));

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic look(input int idx, input int exp, input string tag);
    lidx = IW'(idx); #1;
    chk(tag, int'(lk), exp);
  endtask

  task automatic rep_err(input int idx, input logic c, input logic v = 1'b1);
    @(negedge clk); ev = v; ce = c; eidx = IW'(idx);
    @(negedge clk); ev = 0; ce = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_reset();
    chk("R1 slot_vld", int'(sv), 0);
    chk("R1 repair", int'(rep), 0);
    chk("R1 bypass", int'(byp), 0);
    look(5, 0, "R1 lookup");
  endtask

  task automatic t_count();
    rep_err(5, 1); rep_err(5, 1);
    look(5, 0, "R2 below threshold");
    rep_err(5, 1);
    look(5, 1, "R2 retired on third");
    chk("R5 slot0 first", int'(sv), 1);
    chk("R5 slot0 idx", int'(s0), 5);
  endtask

  task automatic t_no_ce();
    for (int i = 0; i < 5; i++) rep_err(9, 0);
    for (int i = 0; i < 5; i++) rep_err(9, 1, 1'b0);
    look(9, 0, "R4 uncorrectable and idle not counted");
    chk("R4 slots unchanged", int'(sv), 1);
  endtask

  task automatic t_restart();
    rep_err(7, 1); rep_err(7, 1); rep_err(8, 1); rep_err(7, 1); rep_err(7, 1);
    look(7, 0, "R3 count restarted");
    look(8, 0, "R3 other index");
    rep_err(7, 1);
    look(7, 1, "R3 retired after restart");
    chk("R5 slot1 second", int'(sv), 3);
    chk("R5 slot1 idx", int'(s1), 7);
    look(6, 0, "R5 no false match");
  endtask

  task automatic t_dup();
    for (int i = 0; i < 4; i++) rep_err(5, 1);
    chk("R6 slots", int'(sv), 3);
    chk("R6 slot0 kept", int'(s0), 5);
    chk("R6 no repair", int'(rep), 0);
  endtask

  task automatic t_repair();
    rep_err(11, 1); rep_err(11, 1); rep_err(11, 1);
    chk("R7 repair set", int'(rep), 1);
    chk("R7 slot0 kept", int'(s0), 5);
    chk("R7 slot1 kept", int'(s1), 7);
    look(11, 0, "R7 third line not retired");
  endtask

  task automatic t_boot_bypass();
    @(negedge clk); boot = 1; @(negedge clk); boot = 0;
    chk("R8 bypass entered", int'(byp), 1);
    chk("R7 repair survives boot", int'(rep), 1);
    look(300, 1, "R9 lookup all");
    rep_err(12, 1); rep_err(12, 1); rep_err(12, 1);
    chk("R9 slots frozen", int'(sv), 3);
    chk("R9 slot1 frozen", int'(s1), 7);
  endtask

  task automatic t_boot_clean();
    do_reset();
    chk("R1 bypass cleared", int'(byp), 0);
    rep_err(20, 1); rep_err(20, 1);
    @(negedge clk); boot = 1; @(negedge clk); boot = 0;
    chk("R8 no bypass without repair", int'(byp), 0);
    rep_err(20, 1);
    look(20, 0, "R8 count cleared by boot");
    thr = 0;
    rep_err(21, 1);
    look(21, 1, "R2 zero threshold");
    thr = 2;
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_count();
    t_no_ce();
    t_restart();
    t_dup();
    t_repair();
    t_boot_bypass();
    t_boot_clean();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule